// File: doc/BRIEF.md
# Chip Memory DMA Slot Arbiter

This block decides, once per memory slot, which requester drives the shared chip-memory bus. The requesters are the bitplane fetcher, the disk engine, the display coprocessor and the blitter. The CPU takes any slot that none of them claims. The caller presents a slot number with a strobe, together with the current line number, the horizontal fetch-window bounds and a vertical fetch flag. One clock later the block answers with exactly one registered grant. For a bitplane grant it also gives the plane index to fetch.

Each DMA requester is gated by its own enable bit in a 16-bit control register. A write to that register sets or clears bits according to its top bit. A read returns the register with a blitter-busy flag merged in. A second, write-only mode nibble selects low or high resolution and the number of active planes. Within an 8-slot fetch group the plane order is fixed: six of the eight positions are used in low resolution and all eight in high resolution. Positions that are free, or whose plane lies beyond the plane count, fall through to the odd/even priority chain. The memory, the coprocessor and the blitter engines are outside this block.

Top module: `dma_slot_arbiter`

## Requirements
- R1: A write to the control register with data bit 15 = 1 sets every register bit whose data bit in 14:0 is 1. With bit 15 = 0 it clears those bits. The read port returns the register in bits 14:0 and the blitter-busy input ORed into bit 14 (bit 15 reads 0), one clock after the state changes. Enable bits: bitplane = 8, coprocessor = 7, blitter = 6, disk = 4.
- R2: The horizontal fetch flag becomes set in the slot whose number equals the window start, and that slot already counts as a fetch slot. It becomes clear in the slot equal to the window stop, and that slot is not a fetch slot. A slot is eligible for bitplanes only if bitplane DMA is enabled, the horizontal flag is set and the vertical fetch flag input is 1.
- R3: In low resolution, the group position is the count of eligible slots since the last group reset, modulo 8. Positions 1, 2, 3, 5, 6 and 7 fetch planes 3, 5, 1, 2, 4 and 0. Positions 0 and 4 are free.
- R4: A plane is fetched only when its index is below the plane count. The count is bits 2:0 of the mode nibble, which are bits 14:12 of the bitplane control word. The value 7 acts as 4.
- R5: In high resolution (mode nibble bit 3, which is control word bit 15), positions 0 to 3 after a group reset are free. After that, position p fetches plane 3, 1, 2, 0 for p mod 4 = 0, 1, 2, 3.
- R6: An odd slot not taken by bitplanes goes to the disk only when the slot number is in 4 to 6, disk DMA is enabled and the disk requests.
- R7: An even slot not taken by bitplanes goes to the coprocessor when coprocessor DMA is enabled and it requests. On such a slot the beam output is {line[7:0], slot with bit 0 cleared}. With coprocessor DMA disabled, the stop output pulses on such a slot instead.
- R8: A slot still unclaimed goes to the blitter when blitter DMA is enabled and it requests, and otherwise to the CPU. Exactly one grant is given per slot.
- R9: At a line-end pulse, the group position and the high-resolution skip count return to 0 only if a bitplane was fetched since the previous line end. Otherwise they carry on.
- R10: Grants, the plane index, the beam and the stop pulse are registered. They appear in the clock after the slot strobe and are all 0 in a clock that follows no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 1 | A memory slot is being arbitrated this clock |
| slot_idx | input | SLOT_W | Slot number within the line |
| line_idx | input | LINE_W | Current line number |
| line_end | input | 1 | End-of-line pulse |
| fetch_start | input | SLOT_W | Horizontal fetch-window start slot |
| fetch_stop | input | SLOT_W | Horizontal fetch-window stop slot |
| vfetch | input | 1 | Vertical fetch flag |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data, bit 15 = set/clear |
| ctl_rdata | output | 16 | Control register read value |
| blit_busy | input | 1 | Blitter busy status |
| mode_wr | input | 1 | Mode nibble write strobe |
| mode_wdata | input | 4 | Bit 3 high resolution, bits 2:0 plane count |
| disk_req | input | 1 | Disk engine request |
| disk_gnt | output | 1 | Disk granted |
| cop_req | input | 1 | Coprocessor request |
| cop_gnt | output | 1 | Coprocessor granted |
| cop_stop | output | 1 | Coprocessor told to stop |
| cop_beam | output | LINE_W+SLOT_W | Beam position given to the coprocessor |
| blit_req | input | 1 | Blitter request |
| blit_gnt | output | 1 | Blitter granted |
| bpl_gnt | output | 1 | Bitplane fetch granted |
| bpl_plane | output | 3 | Plane index for the bitplane fetch |
| cpu_gnt | output | 1 | CPU granted |

## Verification
The hardest state to reach from the ports is the group position when the plane count suppresses every fetch. The counter then advances without a fetch, and the next line end must leave it in place. The bench gets there with a zero plane count: it runs three eligible slots and pulses line end. It then restores six planes and checks that the next slot fetches the plane for position 3 and not position 0. The high-resolution skip is reached the same way, by a line end that follows a real fetch. This resets the group so that the first four eligible slots can be seen going free.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    OWN_BPL, OWN_DISK, OWN_COP, OWN_BLIT, OWN_CPU
  } owner_e;

  // {valid, plane} for a low-resolution group position
  function automatic logic [3:0] lores_pick(input logic [2:0] pos);
    case (pos)
      3'd1:    return 4'b1011;
      3'd2:    return 4'b1101;
      3'd3:    return 4'b1001;
      3'd5:    return 4'b1010;
      3'd6:    return 4'b1100;
      3'd7:    return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [2:0] hires_plane(input logic [1:0] pos);
    case (pos)
      2'd0:    return 3'd3;
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] fold_count(input logic [2:0] cnt);
    return (cnt == 3'd7) ? 3'd4 : cnt;
  endfunction
endpackage

// File: rtl/dmactl_reg.sv
module dmactl_reg #(
  parameter int BUSY_BIT = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        busy,
  output logic [14:0] ctl_q,
  output logic [15:0] rdata
);
  localparam logic [15:0] BUSY_MASK = 16'(1) << BUSY_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr) begin
      if (wdata[15]) ctl_q <= ctl_q | wdata[14:0];
      else           ctl_q <= ctl_q & ~wdata[14:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {1'b0, ctl_q} | (busy ? BUSY_MASK : 16'd0);
  end
endmodule

// File: rtl/fetch_tracker.sv
module fetch_tracker #(
  parameter int SLOT_W = 8,
  parameter int GROUP  = 8,
  parameter int SKIP   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          slot_valid,
  input  logic [SLOT_W-1:0]             slot_idx,
  input  logic [SLOT_W-1:0]             win_start,
  input  logic [SLOT_W-1:0]             win_stop,
  input  logic                          vfetch,
  input  logic                          bpl_en,
  input  logic                          line_end,
  input  logic                          fetch_now,
  output logic                          eligible,
  output logic [$clog2(GROUP)-1:0]      pos,
  output logic                          warm
);
  localparam int POS_W = $clog2(GROUP);
  localparam logic [POS_W-1:0] LAST_COLD = POS_W'(SKIP - 1);

  logic             hflag_q;
  logic             h_now;
  logic [POS_W-1:0] off_q;
  logic             warm_q;
  logic             fetched_q;

  assign h_now    = (hflag_q | (slot_idx == win_start)) & (slot_idx != win_stop);
  assign eligible = bpl_en & vfetch & h_now;
  assign pos      = off_q;
  assign warm     = warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hflag_q <= 1'b0;
    end else if (slot_valid) begin
      hflag_q <= h_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= '0;
      warm_q    <= 1'b0;
      fetched_q <= 1'b0;
    end else begin
      if (slot_valid && eligible) begin
        off_q <= off_q + 1'b1;
        if (off_q == LAST_COLD) warm_q <= 1'b1;
      end
      if (slot_valid && fetch_now) fetched_q <= 1'b1;
      if (line_end) begin
        fetched_q <= 1'b0;
        if (fetched_q || (slot_valid && fetch_now)) begin
          off_q  <= '0;
          warm_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/plane_picker.sv
module plane_picker (
  input  logic [2:0] pos,
  input  logic       warm,
  input  logic       hires,
  input  logic [2:0] count,
  output logic       take,
  output logic [2:0] plane
);
  import arb_pkg::*;

  logic [3:0] lo;
  logic [2:0] hi;
  logic [2:0] cnt;

  assign lo  = lores_pick(pos);
  assign hi  = hires_plane(pos[1:0]);
  assign cnt = fold_count(count);

  always_comb begin
    if (hires) begin
      plane = hi;
      take  = warm & (hi < cnt);
    end else begin
      plane = lo[2:0];
      take  = lo[3] & (lo[2:0] < cnt);
    end
  end
endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter #(
  parameter int SLOT_W      = 8,
  parameter int LINE_W      = 8,
  parameter int BPL_EN_BIT  = 8,
  parameter int COP_EN_BIT  = 7,
  parameter int BLT_EN_BIT  = 6,
  parameter int DSK_EN_BIT  = 4,
  parameter int BUSY_BIT    = 14,
  parameter int DISK_LO     = 4,
  parameter int DISK_HI     = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slot_valid,
  input  logic [SLOT_W-1:0]        slot_idx,
  input  logic [LINE_W-1:0]        line_idx,
  input  logic                     line_end,
  input  logic [SLOT_W-1:0]        fetch_start,
  input  logic [SLOT_W-1:0]        fetch_stop,
  input  logic                     vfetch,
  input  logic                     ctl_wr,
  input  logic [15:0]              ctl_wdata,
  output logic [15:0]              ctl_rdata,
  input  logic                     blit_busy,
  input  logic                     mode_wr,
  input  logic [3:0]               mode_wdata,
  input  logic                     disk_req,
  output logic                     disk_gnt,
  input  logic                     cop_req,
  output logic                     cop_gnt,
  output logic                     cop_stop,
  output logic [LINE_W+SLOT_W-1:0] cop_beam,
  input  logic                     blit_req,
  output logic                     blit_gnt,
  output logic                     bpl_gnt,
  output logic [2:0]               bpl_plane,
  output logic                     cpu_gnt
);
  import arb_pkg::*;

  localparam int BEAM_W = LINE_W + SLOT_W;
  localparam logic [SLOT_W-1:0] DLO = SLOT_W'(DISK_LO);
  localparam logic [SLOT_W-1:0] DHI = SLOT_W'(DISK_HI);

  logic [14:0] ctl_q;
  logic        bpl_en, cop_en, blt_en, dsk_en;
  logic        hires_q;
  logic [2:0]  count_q;
  logic        eligible, warm, pick_take, take_bpl;
  logic [2:0]  pos, pick_plane;
  logic        odd, disk_ok, cop_offer;
  logic [BEAM_W-1:0] beam_now;
  owner_e      win;

  dmactl_reg #(.BUSY_BIT(BUSY_BIT)) u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
    .busy(blit_busy), .ctl_q(ctl_q), .rdata(ctl_rdata)
  );

  assign bpl_en = ctl_q[BPL_EN_BIT];
  assign cop_en = ctl_q[COP_EN_BIT];
  assign blt_en = ctl_q[BLT_EN_BIT];
  assign dsk_en = ctl_q[DSK_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      hires_q <= 1'b0;
      count_q <= '0;
    end else if (mode_wr) begin
      hires_q <= mode_wdata[3];
      count_q <= mode_wdata[2:0];
    end
  end

  fetch_tracker #(.SLOT_W(SLOT_W), .GROUP(8), .SKIP(4)) u_trk (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_idx(slot_idx),
    .win_start(fetch_start), .win_stop(fetch_stop), .vfetch(vfetch),
    .bpl_en(bpl_en), .line_end(line_end), .fetch_now(take_bpl),
    .eligible(eligible), .pos(pos), .warm(warm)
  );

  plane_picker u_pick (
    .pos(pos), .warm(warm), .hires(hires_q), .count(count_q),
    .take(pick_take), .plane(pick_plane)
  );

  assign take_bpl  = eligible & pick_take;
  assign odd       = slot_idx[0];
  assign disk_ok   = dsk_en & disk_req & (slot_idx >= DLO) & (slot_idx <= DHI);
  assign cop_offer = ~odd & ~take_bpl;
  assign beam_now  = {line_idx, slot_idx[SLOT_W-1:1], 1'b0};

  always_comb begin
    if (take_bpl)                      win = OWN_BPL;
    else if (odd && disk_ok)           win = OWN_DISK;
    else if (!odd && cop_en && cop_req) win = OWN_COP;
    else if (blt_en && blit_req)       win = OWN_BLIT;
    else                               win = OWN_CPU;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bpl_gnt   <= 1'b0;
      bpl_plane <= '0;
      disk_gnt  <= 1'b0;
      cop_gnt   <= 1'b0;
      blit_gnt  <= 1'b0;
      cpu_gnt   <= 1'b0;
      cop_stop  <= 1'b0;
      cop_beam  <= '0;
    end else begin
      bpl_gnt   <= slot_valid && (win == OWN_BPL);
      bpl_plane <= (slot_valid && (win == OWN_BPL)) ? pick_plane : 3'd0;
      disk_gnt  <= slot_valid && (win == OWN_DISK);
      cop_gnt   <= slot_valid && (win == OWN_COP);
      blit_gnt  <= slot_valid && (win == OWN_BLIT);
      cpu_gnt   <= slot_valid && (win == OWN_CPU);
      cop_stop  <= slot_valid && cop_offer && !cop_en;
      cop_beam  <= (slot_valid && cop_offer && cop_en) ? beam_now : '0;
    end
  end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int SLOT_W  = 8,
  parameter int DISK_LO = 4,
  parameter int DISK_HI = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_valid,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [SLOT_W-1:0] fetch_stop,
  input logic              bpl_gnt,
  input logic              disk_gnt,
  input logic              cop_gnt,
  input logic              cop_stop,
  input logic              blit_gnt,
  input logic              cpu_gnt
);
  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    slot_valid |=> $countones({bpl_gnt, disk_gnt, cop_gnt, blit_gnt, cpu_gnt}) == 1);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_valid |=> !(bpl_gnt || disk_gnt || cop_gnt || blit_gnt || cpu_gnt || cop_stop));

  // R6
  disk_window_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && (!slot_idx[0] || slot_idx < SLOT_W'(DISK_LO) || slot_idx > SLOT_W'(DISK_HI)))
      |=> !disk_gnt);

  // R7
  cop_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_idx[0]) |=> !(cop_gnt || cop_stop));

  // R2
  stop_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_idx == fetch_stop) |=> !bpl_gnt);
endmodule

bind dma_slot_arbiter arb_chk #(.SLOT_W(SLOT_W), .DISK_LO(DISK_LO), .DISK_HI(DISK_HI)) u_chk (
  .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_idx(slot_idx),
  .fetch_stop(fetch_stop), .bpl_gnt(bpl_gnt), .disk_gnt(disk_gnt),
  .cop_gnt(cop_gnt), .cop_stop(cop_stop), .blit_gnt(blit_gnt), .cpu_gnt(cpu_gnt)
);

// File: tb/dma_slot_arbiter_test.sv
module dma_slot_arbiter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_valid = 0;
  logic [7:0]  slot_idx = 0;
  logic [7:0]  line_idx = 0;
  logic        line_end = 0;
  logic [7:0]  fetch_start = 8'd16;
  logic [7:0]  fetch_stop = 8'd25;
  logic        vfetch = 0;
  logic        ctl_wr = 0;
  logic [15:0] ctl_wdata = 0;
  logic [15:0] ctl_rdata;
  logic        blit_busy = 0;
  logic        mode_wr = 0;
  logic [3:0]  mode_wdata = 0;
  logic        disk_req = 0, cop_req = 0, blit_req = 0;
  logic        disk_gnt, cop_gnt, cop_stop, blit_gnt, bpl_gnt, cpu_gnt;
  logic [15:0] cop_beam;
  logic [2:0]  bpl_plane;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_slot_arbiter uut (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_idx(slot_idx),
    .line_idx(line_idx), .line_end(line_end), .fetch_start(fetch_start),
    .fetch_stop(fetch_stop), .vfetch(vfetch), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .blit_busy(blit_busy),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .disk_req(disk_req),
    .disk_gnt(disk_gnt), .cop_req(cop_req), .cop_gnt(cop_gnt),
    .cop_stop(cop_stop), .cop_beam(cop_beam), .blit_req(blit_req),
    .blit_gnt(blit_gnt), .bpl_gnt(bpl_gnt), .bpl_plane(bpl_plane),
    .cpu_gnt(cpu_gnt)
  );

  // owner codes: 0 bitplane, 1 disk, 2 coprocessor, 3 blitter, 4 CPU, 7 none
  function automatic logic [2:0] owner();
    if (bpl_gnt)  return 3'd0;
    if (disk_gnt) return 3'd1;
    if (cop_gnt)  return 3'd2;
    if (blit_gnt) return 3'd3;
    if (cpu_gnt)  return 3'd4;
    return 3'd7;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_slot(input logic [7:0] s);
    @(negedge clk); slot_valid = 1; slot_idx = s;
    @(negedge clk); slot_valid = 0;
  endtask

  task automatic pulse_line_end();
    @(negedge clk); line_end = 1;
    @(negedge clk); line_end = 0;
  endtask

  task automatic write_ctl(input logic [15:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [3:0] v);
    @(negedge clk); mode_wr = 1; mode_wdata = v;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic expect_slot(input string req, input logic [7:0] s,
                             input logic [2:0] who, input logic [2:0] pl);
    run_slot(s);
    check(req, {13'd0, owner()}, {13'd0, who});
    if (who == 3'd0) check(req, {13'd0, bpl_plane}, {13'd0, pl});
  endtask

  // {slot, owner, plane}: low resolution, 6 planes, window 16..25, all requesters on
  localparam logic [13:0] VEC [16] = '{
    {8'd14, 3'd2, 3'd0}, {8'd15, 3'd3, 3'd0}, {8'd16, 3'd2, 3'd0}, {8'd17, 3'd0, 3'd3},
    {8'd18, 3'd0, 3'd5}, {8'd19, 3'd0, 3'd1}, {8'd20, 3'd2, 3'd0}, {8'd21, 3'd0, 3'd2},
    {8'd22, 3'd0, 3'd4}, {8'd23, 3'd0, 3'd0}, {8'd24, 3'd2, 3'd0}, {8'd25, 3'd3, 3'd0},
    {8'd26, 3'd2, 3'd0}, {8'd27, 3'd3, 3'd0}, {8'd28, 3'd2, 3'd0}, {8'd29, 3'd3, 3'd0}
  };

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 reset grants", {10'd0, bpl_gnt, disk_gnt, cop_gnt, blit_gnt, cpu_gnt, cop_stop}, 16'd0);
    check("R1 reset read", ctl_rdata, 16'h0000);

    // R1 set, busy merge, clear
    write_ctl(16'h81D0);
    check("R1 set bits", ctl_rdata, 16'h01D0);
    blit_busy = 1;
    @(negedge clk);
    check("R1 busy in bit 14", ctl_rdata, 16'h41D0);
    blit_busy = 0;
    write_ctl(16'h0040);
    check("R1 clear bit", ctl_rdata, 16'h0190);
    write_ctl(16'h8040);
    check("R1 set again", ctl_rdata, 16'h01D0);

    write_mode(4'h6);
    vfetch = 1; disk_req = 1; cop_req = 1; blit_req = 1;

    // R2 R3 R7 R8: table walk
    for (int i = 0; i < 16; i++) begin
      expect_slot("R3 R2 table", VEC[i][13:6], VEC[i][5:3], VEC[i][2:0]);
    end

    // R9: reset after a fetching line; no reset after a non-fetching line
    fetch_stop = 8'd60;
    pulse_line_end();
    write_mode(4'h0);
    expect_slot("R9 empty pos0", 8'd16, 3'd2, 3'd0);
    expect_slot("R9 empty pos1", 8'd17, 3'd3, 3'd0);
    expect_slot("R9 empty pos2", 8'd18, 3'd2, 3'd0);
    pulse_line_end();
    write_mode(4'h6);
    expect_slot("R9 position kept", 8'd19, 3'd0, 3'd1);

    // R4: count 7 acts as 4
    pulse_line_end();
    write_mode(4'h7);
    expect_slot("R4 pos0 free", 8'd20, 3'd2, 3'd0);
    expect_slot("R4 plane3 allowed", 8'd21, 3'd0, 3'd3);
    expect_slot("R4 plane5 blocked", 8'd22, 3'd2, 3'd0);
    expect_slot("R4 plane1 allowed", 8'd23, 3'd0, 3'd1);

    // R5: high resolution, 4 planes
    pulse_line_end();
    write_mode(4'hC);
    expect_slot("R5 skip0", 8'd20, 3'd2, 3'd0);
    expect_slot("R5 skip1", 8'd21, 3'd3, 3'd0);
    expect_slot("R5 skip2", 8'd22, 3'd2, 3'd0);
    expect_slot("R5 skip3", 8'd23, 3'd3, 3'd0);
    expect_slot("R5 plane3", 8'd24, 3'd0, 3'd3);
    expect_slot("R5 plane1", 8'd25, 3'd0, 3'd1);
    expect_slot("R5 plane2", 8'd26, 3'd0, 3'd2);
    expect_slot("R5 plane0", 8'd27, 3'd0, 3'd0);

    // R6: disk window, bitplane DMA off
    write_ctl(16'h0100);
    expect_slot("R6 disk slot5", 8'd5, 3'd1, 3'd0);
    expect_slot("R6 slot3 not disk", 8'd3, 3'd3, 3'd0);
    expect_slot("R6 slot7 not disk", 8'd7, 3'd3, 3'd0);
    disk_req = 0;
    expect_slot("R6 no request", 8'd5, 3'd3, 3'd0);
    disk_req = 1;
    write_ctl(16'h0010);
    expect_slot("R6 disk disabled", 8'd5, 3'd3, 3'd0);

    // R7: beam, stop, request
    line_idx = 8'hA5;
    run_slot(8'd10);
    check("R7 cop grant", {15'd0, cop_gnt}, 16'd1);
    check("R7 beam", cop_beam, 16'hA50A);
    write_ctl(16'h0080);
    run_slot(8'd10);
    check("R7 stop pulse", {15'd0, cop_stop}, 16'd1);
    check("R7 disabled goes blitter", {13'd0, owner()}, 16'd3);
    write_ctl(16'h8080);
    cop_req = 0;
    run_slot(8'd12);
    check("R7 no request", {14'd0, cop_stop, cop_gnt}, 16'd0);
    check("R8 to blitter", {13'd0, owner()}, 16'd3);

    // R8: CPU fallback
    blit_req = 0;
    expect_slot("R8 cpu no request", 8'd12, 3'd4, 3'd0);
    blit_req = 1;
    write_ctl(16'h0040);
    expect_slot("R8 cpu blit disabled", 8'd13, 3'd4, 3'd0);

    // R10: idle clock after a slot
    run_slot(8'd14);
    @(negedge clk);
    check("R10 idle", {10'd0, bpl_gnt, disk_gnt, cop_gnt, blit_gnt, cpu_gnt, cop_stop}, 16'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule